// File: doc/BRIEF.md
# Ping-Pong Channel Coefficient Loader

This block sits between a host-fed FIFO and a bank of four tap-delay filters that model a 2×2 radio channel. Each profile consists of 72 signed 16-bit tap weights, 18 for each of the four filters. The host sends each profile as 32-bit words. The loader pops one word per cycle while the FIFO holds data. It splits each word into two weights and writes them into the half of a two-bank coefficient store that the filters are not using.

After the 36 weight words, one more word carries the profile's 4-bit gain exponent. When that word has been stored, the loaded bank counts as complete and the loader stops popping. A periodic refresh pulse promotes a complete bank to active and hands the other bank back to the loader. A refresh pulse that finds no complete profile leaves the filters on their current weights and records a sticky underrun. The filters read the active bank through a registered port addressed by filter and tap.

Top module: `chan_prof_loader`

## Requirements
- R1: After reset, bank 0 is active, every stored weight reads as 0, the active gain is 0, underrun is 0 and no FIFO word is popped.
- R2: `fifo_pop` is high exactly when `fifo_empty` is low and the loading bank is not yet complete; a popped word is the one present on `fifo_word` in that cycle.
- R3: Word n (n = 0..35) of a profile carries weight index 2n in bits [15:0] and weight index 2n+1 in bits [31:16]; weight index k belongs to filter k / 18, tap k mod 18.
- R4: Word 36 of a profile supplies the gain exponent in bits [3:0]; bits [31:4] are ignored; storing it marks the loading bank complete.
- R5: Writes only ever go to the inactive bank; weights read from the active bank do not change while a profile loads.
- R6: A refresh pulse while the loading bank is complete flips `active_bank` on the next cycle, presents that profile's gain on `active_gain`, and restarts loading at word 0 into the bank just released.
- R7: A refresh pulse while the loading bank is incomplete leaves `active_bank`, the weights being read and the loading progress unchanged, and sets `underrun`, which then stays set until reset.
- R8: While the loading bank is complete and no swap has occurred, no further FIFO words are popped, even if the FIFO holds data.
- R9: `coef_out` shows the active-bank weight for the filter and tap presented one cycle earlier; a tap number of 18 or more reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_empty | input | 1 | FIFO has no word available |
| fifo_word | input | 32 | Word at the FIFO head (show-ahead) |
| fifo_pop | output | 1 | Consume the head word this cycle |
| refresh | input | 1 | One-cycle refresh pulse |
| rd_filter | input | 2 | Filter number for the read port |
| rd_tap | input | 5 | Tap number for the read port |
| coef_out | output | 16 | Active-bank weight, one cycle after the address |
| active_bank | output | 1 | Bank currently feeding the filters |
| active_gain | output | 4 | Gain exponent of the active profile |
| underrun | output | 1 | Sticky: a refresh found no complete profile |

## Verification
On every cycle, the assertions check the following: the pop never fires on an empty FIFO or into a complete bank, writes never land in the active bank, the result of each refresh pulse (swap or underrun) and the stickiness of underrun, and the zero read for out-of-range taps. Only the bench scenarios can show the rest. These cover the placement of every unpacked half-word at its filter and tap, that the gain comes only from the low bits of the trailing word, and that weights seen by the filters stay frozen through partial loads. They also cover a second queued profile waiting untouched in the FIFO until a swap frees a bank, and a loaded profile filling the released bank from word 0.

// File: rtl/cpl_pkg.sv
package cpl_pkg;
    localparam int CPL_FILTERS = 4;
    localparam int CPL_TAPS    = 18;
    localparam int CPL_COEF_W  = 16;
    localparam int CPL_GAIN_W  = 4;
endpackage

// File: rtl/cpl_ctrl.sv
module cpl_ctrl #(
    parameter int NUM_FILT = cpl_pkg::CPL_FILTERS,
    parameter int NUM_TAPS = cpl_pkg::CPL_TAPS,
    parameter int COEF_W   = cpl_pkg::CPL_COEF_W,
    parameter int GAIN_W   = cpl_pkg::CPL_GAIN_W,
    localparam int PROF_LEN = NUM_FILT * NUM_TAPS,
    localparam int WORDS    = PROF_LEN / 2,
    localparam int WCNT_W   = $clog2(WORDS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fifo_empty,
    input  logic [2*COEF_W-1:0] fifo_word,
    output logic                fifo_pop,
    input  logic                refresh,
    output logic                wr_en,
    output logic                wr_bank,
    output logic [WCNT_W-1:0]   wr_pair,
    output logic [COEF_W-1:0]   wr_lo,
    output logic [COEF_W-1:0]   wr_hi,
    output logic                active_bank,
    output logic [GAIN_W-1:0]   active_gain,
    output logic                underrun
);
    typedef struct packed {
        logic [WCNT_W-1:0] wcnt;
        logic              full;
        logic              active;
        logic              underrun;
        logic [GAIN_W-1:0] gain0;
        logic [GAIN_W-1:0] gain1;
    } state_t;

    state_t st_d, st_q;
    logic   pop_d;
    logic   at_gain;

    always_comb begin
        st_d    = st_q;
        at_gain = (st_q.wcnt == WCNT_W'(WORDS));
        pop_d   = !fifo_empty && !st_q.full;
        if (pop_d) begin
            if (at_gain) begin
                st_d.full = 1'b1;
                if (st_q.active) st_d.gain0 = fifo_word[GAIN_W-1:0];
                else             st_d.gain1 = fifo_word[GAIN_W-1:0];
            end else begin
                st_d.wcnt = st_q.wcnt + 1'b1;
            end
        end
        if (refresh) begin
            if (st_q.full) begin
                st_d.active = ~st_q.active;
                st_d.full   = 1'b0;
                st_d.wcnt   = '0;
            end else begin
                st_d.underrun = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fifo_pop    = pop_d;
    assign wr_en       = pop_d && !at_gain;
    assign wr_bank     = ~st_q.active;
    assign wr_pair     = st_q.wcnt;
    assign wr_lo       = fifo_word[COEF_W-1:0];
    assign wr_hi       = fifo_word[2*COEF_W-1:COEF_W];
    assign active_bank = st_q.active;
    assign active_gain = st_q.active ? st_q.gain1 : st_q.gain0;
    assign underrun    = st_q.underrun;

    // R2
    pop_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);
    // R8
    hold_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.full && !refresh) |=> !fifo_pop);
    // R6
    swap_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh && st_q.full) |=> (active_bank != $past(active_bank)) && (st_q.wcnt == '0));
    // R7
    underrun_hold_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh && !st_q.full) |=> underrun && (active_bank == $past(active_bank)));
    // R7
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);
endmodule

// File: rtl/cpl_bank.sv
module cpl_bank #(
    parameter int NUM_FILT = cpl_pkg::CPL_FILTERS,
    parameter int NUM_TAPS = cpl_pkg::CPL_TAPS,
    parameter int COEF_W   = cpl_pkg::CPL_COEF_W,
    localparam int PROF_LEN = NUM_FILT * NUM_TAPS,
    localparam int WORDS    = PROF_LEN / 2,
    localparam int WCNT_W   = $clog2(WORDS + 1),
    localparam int ENTRIES  = 2 * PROF_LEN,
    localparam int IDX_W    = $clog2(ENTRIES),
    localparam int FILT_W   = $clog2(NUM_FILT),
    localparam int TAP_W    = $clog2(NUM_TAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [WCNT_W-1:0] wr_pair,
    input  logic [COEF_W-1:0] wr_lo,
    input  logic [COEF_W-1:0] wr_hi,
    input  logic              rd_bank,
    input  logic [FILT_W-1:0] rd_filter,
    input  logic [TAP_W-1:0]  rd_tap,
    output logic [COEF_W-1:0] coef_out
);
    logic [COEF_W-1:0] mem_d [ENTRIES];
    logic [COEF_W-1:0] mem_q [ENTRIES];
    logic [COEF_W-1:0] rd_d, rd_q;
    logic [IDX_W-1:0]  widx, ridx;
    logic              in_range;

    always_comb begin
        mem_d = mem_q;
        widx  = (wr_bank ? IDX_W'(PROF_LEN) : '0) + IDX_W'(wr_pair) + IDX_W'(wr_pair);
        if (wr_en) begin
            mem_d[widx]        = wr_lo;
            mem_d[widx + 1'b1] = wr_hi;
        end
        in_range = (int'(rd_tap) < NUM_TAPS) && (int'(rd_filter) < NUM_FILT);
        ridx     = (rd_bank ? IDX_W'(PROF_LEN) : '0)
                 + IDX_W'(rd_filter) * IDX_W'(NUM_TAPS) + IDX_W'(rd_tap);
        rd_d     = in_range ? mem_q[ridx] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) mem_q[e] <= '0;
            rd_q <= '0;
        end else begin
            mem_q <= mem_d;
            rd_q  <= rd_d;
        end
    end

    assign coef_out = rd_q;

    // R5
    no_active_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_bank != rd_bank));
    // R9
    oob_tap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_tap) >= NUM_TAPS) |=> (coef_out == '0));
endmodule

// File: rtl/chan_prof_loader.sv
module chan_prof_loader #(
    parameter int NUM_FILT = cpl_pkg::CPL_FILTERS,
    parameter int NUM_TAPS = cpl_pkg::CPL_TAPS,
    parameter int COEF_W   = cpl_pkg::CPL_COEF_W,
    parameter int GAIN_W   = cpl_pkg::CPL_GAIN_W,
    localparam int FILT_W  = $clog2(NUM_FILT),
    localparam int TAP_W   = $clog2(NUM_TAPS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fifo_empty,
    input  logic [2*COEF_W-1:0] fifo_word,
    output logic                fifo_pop,
    input  logic                refresh,
    input  logic [FILT_W-1:0]   rd_filter,
    input  logic [TAP_W-1:0]    rd_tap,
    output logic [COEF_W-1:0]   coef_out,
    output logic                active_bank,
    output logic [GAIN_W-1:0]   active_gain,
    output logic                underrun
);
    localparam int WCNT_W = $clog2(NUM_FILT * NUM_TAPS / 2 + 1);

    logic              wr_en, wr_bank;
    logic [WCNT_W-1:0] wr_pair;
    logic [COEF_W-1:0] wr_lo, wr_hi;

    cpl_ctrl #(.NUM_FILT(NUM_FILT), .NUM_TAPS(NUM_TAPS), .COEF_W(COEF_W), .GAIN_W(GAIN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_word(fifo_word),
        .fifo_pop(fifo_pop), .refresh(refresh), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_pair(wr_pair), .wr_lo(wr_lo), .wr_hi(wr_hi), .active_bank(active_bank),
        .active_gain(active_gain), .underrun(underrun)
    );

    cpl_bank #(.NUM_FILT(NUM_FILT), .NUM_TAPS(NUM_TAPS), .COEF_W(COEF_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_pair(wr_pair),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .rd_bank(active_bank), .rd_filter(rd_filter),
        .rd_tap(rd_tap), .coef_out(coef_out)
    );
endmodule

// File: tb/chan_prof_loader_bench.sv
module chan_prof_loader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TAPS = 18;
    localparam int LEN  = 72;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        refresh = 1'b0;
    logic [1:0]  rd_filter = '0;
    logic [4:0]  rd_tap = '0;
    logic        fifo_pop, active_bank, underrun;
    logic [15:0] coef_out;
    logic [3:0]  active_gain;

    logic [31:0] fmem [256];
    int          wptr = 0;
    int          rptr = 0;
    logic        fifo_empty;
    logic [31:0] fifo_word;
    assign fifo_empty = (wptr == rptr);
    assign fifo_word  = fmem[rptr % 256];

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) if (fifo_pop) rptr <= rptr + 1;

    chan_prof_loader u_chan_prof_loader (
        .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_word(fifo_word),
        .fifo_pop(fifo_pop), .refresh(refresh), .rd_filter(rd_filter), .rd_tap(rd_tap),
        .coef_out(coef_out), .active_bank(active_bank), .active_gain(active_gain),
        .underrun(underrun)
    );

    function automatic logic [15:0] cv(int p, int k);
        return 16'((p * 4099 + k * 977 + 3) % 65536);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push_words(int p, int gain, int first, int last, int gap);
        for (int j = first; j < last; j++) begin
            @(negedge clk);
            if (j < LEN/2) fmem[wptr % 256] = {cv(p, 2*j+1), cv(p, 2*j)};
            else           fmem[wptr % 256] = 32'hDEADBEE0 | 32'(gain);
            wptr = wptr + 1;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic tick();
        @(negedge clk) refresh = 1'b1;
        @(negedge clk) refresh = 1'b0;
    endtask

    task automatic rd_chk(string req, int f, int t, logic [15:0] exp);
        @(negedge clk);
        rd_filter = 2'(f);
        rd_tap    = 5'(t);
        @(negedge clk);
        chk(req, 32'(coef_out), 32'(exp));
    endtask

    task automatic sweep(string req, int p);
        for (int k = 0; k < LEN; k++) rd_chk(req, k / TAPS, k % TAPS, cv(p, k));
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 bank", 32'(active_bank), 0);
        chk("R1 gain", 32'(active_gain), 0);
        chk("R1 underrun", 32'(underrun), 0);
        chk("R1 pop", 32'(fifo_pop), 0);
        rd_chk("R1 coef", 2, 7, 16'h0);

        // R2 R3 R4 R5: load profile 1 into bank 1 while bank 0 is read
        push_words(1, 5, 0, 37, 0);
        repeat (6) @(negedge clk);
        chk("R2 words consumed", 32'(rptr), 37);
        chk("R8 pop idle when complete", 32'(fifo_pop), 0);
        rd_chk("R5 active untouched", 0, 0, 16'h0);
        rd_chk("R5 active untouched", 3, 17, 16'h0);
        chk("R7 no underrun yet", 32'(underrun), 0);

        // R6 swap
        tick();
        chk("R6 bank flipped", 32'(active_bank), 1);
        chk("R4 gain low bits", 32'(active_gain), 5);
        sweep("R3 unpack profile 1", 1);
        rd_chk("R9 tap 18 reads zero", 1, 18, 16'h0);
        rd_chk("R9 tap 31 reads zero", 3, 31, 16'h0);

        // R7 partial load then tick
        push_words(2, 9, 0, 20, 2);
        repeat (4) @(negedge clk);
        tick();
        chk("R7 bank kept", 32'(active_bank), 1);
        chk("R7 underrun set", 32'(underrun), 1);
        chk("R7 gain kept", 32'(active_gain), 5);
        rd_chk("R5 active during load", 0, 5, cv(1, 5));
        rd_chk("R5 active during load", 2, 11, cv(1, 47));
        push_words(2, 9, 20, 37, 1);
        repeat (6) @(negedge clk);
        tick();
        chk("R6 bank flipped", 32'(active_bank), 0);
        chk("R4 gain profile 2", 32'(active_gain), 9);
        chk("R7 underrun sticky", 32'(underrun), 1);
        sweep("R3 unpack profile 2", 2);

        // R8: two profiles queued, second waits
        push_words(3, 12, 0, 37, 0);
        push_words(4, 3, 0, 37, 0);
        repeat (10) @(negedge clk);
        chk("R8 second profile held", 32'(wptr - rptr), 37);
        chk("R8 pop idle", 32'(fifo_pop), 0);
        tick();
        chk("R6 bank flipped", 32'(active_bank), 1);
        chk("R6 gain profile 3", 32'(active_gain), 12);
        repeat (45) @(negedge clk);
        chk("R6 reload drained FIFO", 32'(wptr - rptr), 0);
        rd_chk("R5 active during reload", 1, 0, cv(3, 18));
        tick();
        chk("R6 bank flipped", 32'(active_bank), 0);
        chk("R4 gain profile 4", 32'(active_gain), 3);
        sweep("R6 restart at word 0 profile 4", 4);

        finish_run();
    end
endmodule